// File: doc/BRIEF.md
# Handshake crossing protocol monitor

This block is a synthesizable run-time checker for a four-phase request/acknowledge handshake that carries a data bus from one clock domain to another. It lives entirely in the source clock domain. It watches the request driven by the source, the acknowledge as it arrives back after its two-stage synchronizer, and the data bus being offered. Any departure from the handshake rules is recorded as an error.

Four faults are detected. An acknowledge that does not arrive within a parameterized number of cycles is a timeout. A data bus that moves while the destination may still be sampling it is a stability fault. A request withdrawn before the acknowledge has been seen is an early release. A new request raised while the previous acknowledge is still active is an overlap. Each fault sets a sticky flag, which stays until a synchronous clear. Each fault also produces a single-cycle event pulse, so that external counters can tally occurrences. Separate parameters choose the active level of the request and of the acknowledge. Internally the monitor works on normalized levels.

Top module: `hs_xing_monitor`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, every bit of `err_o` and `evt_o` is 0 after that edge, and the monitor returns to its idle phase. A transfer begun after reset is judged afresh.
- R2: With `REQ_ACT_HIGH`=1 the request is active when `req_i` is 1; with 0 it is active when `req_i` is 0. `ACK_ACT_HIGH` sets the level of `ack_i` in the same way. For the same logical handshake, both settings give identical `err_o` and `evt_o`.
- R3: Call the edge at which an active request is first seen from idle the start edge. The acknowledge must be sampled active at one of the `TIMEOUT_CYC` edges that follow the start edge. If it is still inactive at the last of them, `evt_o[0]` pulses and `err_o[0]` sets after that edge, once per request. A later acknowledge then completes the handshake normally.
- R4: The data bus is captured at the start edge. Suppose that, at a later edge, three things hold: the request is still active, the request has not yet been released after the acknowledge, and `data_i` differs from the captured value. Then `evt_o[1]` pulses and `err_o[1]` sets after that edge, at most once per transfer. Values present at the edge where the request is released, or at any later edge, are not checked.
- R5: If the request is sampled inactive at an edge before any acknowledge has been sampled for it, `evt_o[2]` pulses and `err_o[2]` sets after that edge. This also applies when the acknowledge becomes active at that same edge.
- R6: Once the request has been released after an acknowledge, the request may be sampled active again while the acknowledge is still active. In that case `evt_o[3]` pulses and `err_o[3]` sets after that edge, and the new request is tracked as a new transfer. A request raised again after the acknowledge has gone inactive raises no fault.
- R7: Each `err_o` bit stays at 1 until `clr_i` is sampled high at an edge, which clears it. If a new fault of the same kind is detected at that same edge, the bit stays at 1.
- R8: Every `evt_o` pulse lasts exactly one cycle and appears in the same cycle that the matching `err_o` bit becomes set.
- R9: A complete handshake yields no event and no flag when all of these hold: the request rises, the acknowledge arrives within the deadline, the request is then released, the acknowledge is then released, and the data is held throughout the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the sticky error flags |
| req_i | input | 1 | Request from the source, level set by `REQ_ACT_HIGH` |
| ack_i | input | 1 | Acknowledge after its synchronizer, level set by `ACK_ACT_HIGH` |
| data_i | input | DATA_W | Data bus offered to the destination |
| err_o | output | 4 | Sticky flags: bit 0 timeout, bit 1 data change, bit 2 early release, bit 3 overlap |
| evt_o | output | 4 | One-cycle fault pulses, same bit assignment as `err_o` |

## Verification
The bench builds the monitor with `DATA_W`=4 and `TIMEOUT_CYC`=3. This short deadline lets a sweep place the acknowledge on every edge from the first to two edges past the limit. For each acknowledge delay, it also places a single data change on every edge of the transfer, as well as after the window closes. The result is an edge-exact map of when timeout and stability faults must appear. Two copies run side by side: one with both signals active high, one with both active low and driven with inverted levels. Every check therefore also compares the two polarity variants. Directed cases cover early release at each cycle before the deadline, overlap against clean back-to-back requests, clear racing a new fault, and reset in mid-transfer.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;

   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_WAIT_ACK = 2'd1,
      PH_WAIT_REL = 2'd2,
      PH_ACK_LOW  = 2'd3
   } hs_phase_e;

   localparam int FAULT_N    = 4;
   localparam int F_TIMEOUT  = 0;
   localparam int F_DATA     = 1;
   localparam int F_EARLY    = 2;
   localparam int F_OVERLAP  = 3;

endpackage

// File: rtl/hs_level_norm.sv
module hs_level_norm #(
   parameter bit ACT_HIGH = 1'b1
) (
   input  logic raw_i,
   output logic act_o
);

   generate
      if (ACT_HIGH) begin : g_high
         assign act_o = raw_i;
      end else begin : g_low
         assign act_o = ~raw_i;
      end
   endgenerate

endmodule

// File: rtl/hs_phase_fsm.sv
module hs_phase_fsm
   import hs_mon_pkg::*;
#(
   parameter int TIMEOUT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_a,
   input  logic ack_a,
   output logic start_o,
   output logic window_o,
   output logic tmo_evt_o,
   output logic early_evt_o,
   output logic ovl_evt_o
);

   localparam int CNT_W = $clog2(TIMEOUT_CYC + 2);
   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_CYC);
   localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

   generate
      if (TIMEOUT_CYC < 1) begin : g_bad_timeout
         $error("hs_phase_fsm: TIMEOUT_CYC must be at least 1");
      end
   endgenerate

   hs_phase_e        phase_q, phase_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      phase_d     = phase_q;
      cnt_d       = cnt_q;
      start_o     = 1'b0;
      tmo_evt_o   = 1'b0;
      early_evt_o = 1'b0;
      ovl_evt_o   = 1'b0;
      case (phase_q)
         PH_IDLE: begin
            if (req_a) begin
               start_o = 1'b1;
               cnt_d   = CNT_ONE;
               phase_d = PH_WAIT_ACK;
            end
         end
         PH_WAIT_ACK: begin
            if (!req_a) begin
               early_evt_o = 1'b1;
               cnt_d       = '0;
               phase_d     = ack_a ? PH_ACK_LOW : PH_IDLE;
            end else if (ack_a) begin
               cnt_d   = '0;
               phase_d = PH_WAIT_REL;
            end else begin
               if (cnt_q == CNT_LIMIT) begin
                  tmo_evt_o = 1'b1;
               end
               if (cnt_q <= CNT_LIMIT) begin
                  cnt_d = cnt_q + CNT_ONE;
               end
            end
         end
         PH_WAIT_REL: begin
            if (!req_a) begin
               phase_d = PH_ACK_LOW;
            end
         end
         PH_ACK_LOW: begin
            if (req_a) begin
               start_o   = 1'b1;
               ovl_evt_o = ack_a;
               cnt_d     = CNT_ONE;
               phase_d   = PH_WAIT_ACK;
            end else if (!ack_a) begin
               phase_d = PH_IDLE;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   assign window_o = req_a && ((phase_q == PH_WAIT_ACK) || (phase_q == PH_WAIT_REL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

   // R3: the deadline counter never runs past its saturation value
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LIMIT + CNT_ONE);

   // R3: a timeout is only raised while an active request waits without acknowledge
   p_tmo_waiting_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt_o |-> (phase_q == PH_WAIT_ACK) && req_a && !ack_a);

   // R3: after a timeout the monitor keeps waiting for the acknowledge
   p_tmo_keeps_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt_o |=> (phase_q == PH_WAIT_ACK));

   // R6: an overlap starts a new transfer
   p_ovl_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_evt_o |=> (phase_q == PH_WAIT_ACK) && (cnt_q == CNT_ONE));

   // R5: an early release never leaves the monitor waiting for acknowledge
   p_early_leaves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      early_evt_o |=> (phase_q == PH_IDLE) || (phase_q == PH_ACK_LOW));

endmodule

// File: rtl/hs_data_guard.sv
module hs_data_guard #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              window_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              mis_evt_o
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs_data_guard: DATA_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] cap_q;
   logic              seen_q;

   assign mis_evt_o = window_i && !seen_q && (data_i != cap_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q  <= '0;
         seen_q <= 1'b0;
      end else if (start_i) begin
         cap_q  <= data_i;
         seen_q <= 1'b0;
      end else if (mis_evt_o) begin
         seen_q <= 1'b1;
      end
   end

   // R4: the captured value holds for the whole transfer
   p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      window_i && !start_i |=> $stable(cap_q));

   // R4: a second mismatch in the same transfer is not reported
   p_once_per_xfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mis_evt_o && !start_i |=> !mis_evt_o || $past(start_i));

endmodule

// File: rtl/hs_fault_bank.sv
module hs_fault_bank #(
   parameter int NUM = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_i,
   input  logic [NUM-1:0] hit_i,
   output logic [NUM-1:0] evt_o,
   output logic [NUM-1:0] err_o
);

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               evt_o[i] <= 1'b0;
               err_o[i] <= 1'b0;
            end else begin
               evt_o[i] <= hit_i[i];
               err_o[i] <= hit_i[i] | (err_o[i] & ~clr_i);
            end
         end

         // R7: a flag holds until a clear is sampled
         p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            err_o[i] && !clr_i |=> err_o[i]);

         // R8: an event pulse is accompanied by its flag
         p_evt_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[i] |-> err_o[i]);

         // R8: event pulses last a single cycle
         p_evt_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[i] |=> !evt_o[i]);
      end
   endgenerate

   // R1: reset leaves no flag and no event behind
   p_reset_clears_r1: assert property (@(posedge clk)
      !rst_n |=> (err_o == '0) && (evt_o == '0));

endmodule

// File: rtl/hs_xing_monitor.sv
module hs_xing_monitor
   import hs_mon_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int TIMEOUT_CYC  = 16,
   parameter bit REQ_ACT_HIGH = 1'b1,
   parameter bit ACK_ACT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              req_i,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [3:0]        err_o,
   output logic [3:0]        evt_o
);

   generate
      if (FAULT_N != 4) begin : g_bad_fault_n
         $error("hs_xing_monitor: fault set must have four entries");
      end
   endgenerate

   logic               req_a;
   logic               ack_a;
   logic               start;
   logic               window;
   logic [FAULT_N-1:0] hit;

   hs_level_norm #(.ACT_HIGH(REQ_ACT_HIGH)) req_norm_i (
      .raw_i (req_i),
      .act_o (req_a)
   );

   hs_level_norm #(.ACT_HIGH(ACK_ACT_HIGH)) ack_norm_i (
      .raw_i (ack_i),
      .act_o (ack_a)
   );

   hs_phase_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_a       (req_a),
      .ack_a       (ack_a),
      .start_o     (start),
      .window_o    (window),
      .tmo_evt_o   (hit[F_TIMEOUT]),
      .early_evt_o (hit[F_EARLY]),
      .ovl_evt_o   (hit[F_OVERLAP])
   );

   hs_data_guard #(.DATA_W(DATA_W)) guard_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .window_i  (window),
      .data_i    (data_i),
      .mis_evt_o (hit[F_DATA])
   );

   hs_fault_bank #(.NUM(FAULT_N)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr_i),
      .hit_i (hit),
      .evt_o (evt_o),
      .err_o (err_o)
   );

   // R4: a data fault is only reported for an edge inside the capture window
   p_data_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[F_DATA] |-> $past(window));

   // R6: an overlap is only reported while the acknowledge is active
   p_ovl_needs_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[F_OVERLAP] |-> $past(ack_a) && $past(req_a));

endmodule

// File: tb/hs_xing_monitor_tb_top.sv
`timescale 1ns/1ps
module hs_xing_monitor_tb_top;

   localparam int DW  = 4;
   localparam int TMO = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          req = 1'b0;
   logic          ack = 1'b0;
   logic [DW-1:0] dat = '0;
   logic [3:0]    err_h, evt_h, err_l, evt_l;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   hs_xing_monitor #(.DATA_W(DW), .TIMEOUT_CYC(TMO),
                     .REQ_ACT_HIGH(1'b1), .ACK_ACT_HIGH(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_i(req), .ack_i(ack),
      .data_i(dat), .err_o(err_h), .evt_o(evt_h));

   hs_xing_monitor #(.DATA_W(DW), .TIMEOUT_CYC(TMO),
                     .REQ_ACT_HIGH(1'b0), .ACK_ACT_HIGH(1'b0)) dut_n_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .req_i(~req), .ack_i(~ack),
      .data_i(dat), .err_o(err_l), .evt_o(evt_l));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic r, input logic a, input logic [DW-1:0] d);
      req = r;
      ack = a;
      dat = d;
   endtask

   task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s actual=%b expected=%b", tag, got, exp);
      end
   endtask

   task automatic chk_evt(input string tag, input logic [3:0] exp);
      chk(tag, evt_h, exp);
      chk({"R2 low-active ", tag}, evt_l, exp);
   endtask

   task automatic chk_err(input string tag, input logic [3:0] exp);
      chk(tag, err_h, exp);
      chk({"R2 low-active ", tag}, err_l, exp);
   endtask

   task automatic clear_flags();
      drive(1'b0, 1'b0, dat);
      clr = 1'b1;
      tick();
      clr = 1'b0;
      chk_err("R7 clear", 4'b0000);
   endtask

   // Sweep: acknowledge first seen at edge ad, single data change from edge ch (0 = none)
   task automatic sweep_xfer(input int ad, input int ch, input logic [DW-1:0] base);
      logic [3:0] exp_evt;
      logic [3:0] exp_err;
      bit         late;
      bit         dirty;
      late  = (ad > TMO);
      dirty = (ch != 0) && (ch <= ad + 1);
      drive(1'b1, 1'b0, base);
      tick();
      chk_evt("R9 start edge", 4'b0000);
      for (int e = 1; e <= ad + 3; e++) begin
         drive((e <= ad + 1), (e >= ad) && (e <= ad + 2),
               ((ch != 0) && (e >= ch)) ? (base ^ 4'b0001) : base);
         tick();
         exp_evt = 4'b0000;
         if (late && (e == TMO)) exp_evt[0] = 1'b1;
         if (dirty && (e == ch)) exp_evt[1] = 1'b1;
         chk_evt($sformatf("R3 R4 R8 ad=%0d ch=%0d edge=%0d", ad, ch, e), exp_evt);
      end
      exp_err = {2'b00, dirty, late};
      drive(1'b0, 1'b0, dat);
      tick();
      chk_err($sformatf("R7 R9 flags ad=%0d ch=%0d", ad, ch), exp_err);
      chk_evt("R8 quiet after xfer", 4'b0000);
      clear_flags();
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      drive(1'b0, 1'b0, 4'h0);
      rst_n = 1'b0;
      tick();
      tick();
      chk_err("R1 reset flags", 4'b0000);
      chk_evt("R1 reset events", 4'b0000);
      rst_n = 1'b1;
      tick();
      chk_err("R1 idle after reset", 4'b0000);

      // R3 R4 R9 sweep of acknowledge delay and data change position
      for (int ad = 1; ad <= TMO + 2; ad++) begin
         for (int ch = 0; ch <= ad + 3; ch++) begin
            sweep_xfer(ad, ch, 4'(ad + 5 * ch));
         end
      end

      // R5 early release before acknowledge, at every edge inside the deadline
      for (int e = 1; e <= TMO; e++) begin
         drive(1'b1, 1'b0, 4'h9);
         tick();
         for (int k = 1; k < e; k++) begin
            tick();
            chk_evt("R5 waiting", 4'b0000);
         end
         drive(1'b0, 1'b0, 4'h9);
         tick();
         chk_evt($sformatf("R5 early release edge=%0d", e), 4'b0100);
         tick();
         chk_err("R5 early flag sticky", 4'b0100);
         clear_flags();
      end

      // R5 release coinciding with the acknowledge
      drive(1'b1, 1'b0, 4'h3);
      tick();
      drive(1'b0, 1'b1, 4'h3);
      tick();
      chk_evt("R5 release with ack", 4'b0100);
      drive(1'b0, 1'b0, 4'h3);
      tick();
      chk_evt("R5 ack drop quiet", 4'b0000);
      clear_flags();

      // R6 overlap: request again while acknowledge still active
      drive(1'b1, 1'b0, 4'h5); tick();
      drive(1'b1, 1'b1, 4'h5); tick();
      drive(1'b0, 1'b1, 4'h5); tick();
      chk_evt("R6 before overlap", 4'b0000);
      drive(1'b1, 1'b1, 4'hA); tick();
      chk_evt("R6 overlap", 4'b1000);
      drive(1'b1, 1'b1, 4'hA); tick();
      chk_evt("R6 new xfer acked", 4'b0000);
      drive(1'b0, 1'b1, 4'hA); tick();
      drive(1'b0, 1'b0, 4'hA); tick();
      chk_err("R6 overlap flag", 4'b1000);
      clear_flags();

      // R6 clean back-to-back: request after acknowledge drop
      drive(1'b1, 1'b0, 4'h6); tick();
      drive(1'b1, 1'b1, 4'h6); tick();
      drive(1'b0, 1'b1, 4'h6); tick();
      drive(1'b0, 1'b0, 4'h6); tick();
      drive(1'b1, 1'b0, 4'h7); tick();
      chk_evt("R6 back-to-back no overlap", 4'b0000);
      drive(1'b1, 1'b1, 4'h7); tick();
      drive(1'b0, 1'b1, 4'h7); tick();
      drive(1'b0, 1'b0, 4'h7); tick();
      chk_err("R6 R9 back-to-back flags", 4'b0000);

      // R7 clear racing a new fault: set wins
      drive(1'b1, 1'b0, 4'h1); tick();
      drive(1'b0, 1'b0, 4'h1); tick();
      chk_err("R7 first fault", 4'b0100);
      tick();
      chk_err("R7 held without clear", 4'b0100);
      drive(1'b1, 1'b0, 4'h1); tick();
      drive(1'b0, 1'b0, 4'h1);
      clr = 1'b1;
      tick();
      clr = 1'b0;
      chk_err("R7 set beats clear", 4'b0100);
      chk_evt("R8 event with clear", 4'b0100);
      clr = 1'b1;
      tick();
      clr = 1'b0;
      chk_err("R7 clear alone", 4'b0000);

      // R1 reset in mid-transfer after a timeout
      drive(1'b1, 1'b0, 4'h2);
      for (int k = 0; k <= TMO; k++) tick();
      chk_err("R1 timeout before reset", 4'b0001);
      rst_n = 1'b0;
      tick();
      chk_err("R1 reset mid-transfer flags", 4'b0000);
      chk_evt("R1 reset mid-transfer events", 4'b0000);
      drive(1'b0, 1'b0, 4'h2);
      tick();
      rst_n = 1'b1;
      drive(1'b1, 1'b0, 4'hC); tick();
      drive(1'b1, 1'b1, 4'hC); tick();
      drive(1'b0, 1'b1, 4'hC); tick();
      drive(1'b0, 1'b0, 4'hC); tick();
      chk_err("R1 fresh transfer after reset", 4'b0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule